// File: doc/BRIEF.md
# Pseudo-Random Pattern Receive Synchronizer and Status Monitor

This block watches a received serial test stream, taking one bit per clock whenever `rx_valid` is high. It hunts for a 2^15-1 pseudo-random sequence with generator polynomial x^15 + x^14 + 1. While it hunts, its local predictor is loaded straight from the incoming bits. Once 32 bits in a row agree with the prediction, it declares lock. From then on the predictor runs freely, and the block counts mismatches over a sliding 64-bit window. In parallel, two run detectors flag a stuck line, one for long runs of ones and one for long runs of zeros.

The four real-time conditions are in-lock, hunting, all-ones and all-zeros. Each one feeds a sticky event bit that is set on its rising edge. Each event bit has its own mask bit. The OR of all unmasked event bits drives a single interrupt line. Software uses a small register port to read the live conditions, read the event bits, clear event bits by writing ones, and program the masks.

Top module: `bert_rx_monitor`

## Requirements
- R1: `st_ones` rises on the clock edge that takes the 32nd consecutive valid one. It falls on the edge that takes any valid zero.
- R2: `st_zeros` rises on the clock edge that takes the 32nd consecutive valid zero. It falls on the edge that takes any valid one.
- R3: `st_los` is high whenever the receiver is hunting, and this includes the state after reset. It is low when the receiver is locked. `st_los` and `st_sync` are always complementary.
- R4: While hunting, the predictor takes each incoming bit, and the prediction is the XOR of the bits received 15 and 14 positions earlier. `st_sync` rises on the edge that takes the 32nd consecutive matching bit. From reset, an all-zero stream therefore locks on exactly its 32nd bit.
- R5: When locked, the predictor free-runs. The block returns to hunting, with its match count cleared, as soon as 6 or more mismatches fall within the latest 64 valid bits. One error every 13 bits keeps lock; one error every 12 bits loses it.
- R6: A cycle with `rx_valid` low leaves the run counters, the match counter and the predictor unchanged.
- R7: Address 1 holds the event bits: bit0 lock, bit1 hunting, bit2 all-ones, bit3 all-zeros. Each bit is set one edge after its real-time condition rises. Writing a one to a bit clears it, and writing zero has no effect.
- R8: If a rising edge and a write-one-to-clear land on the same bit in the same cycle, the bit ends up set.
- R9: Address 2 holds a read/write mask with the same bit order. `irq` is the OR of all event bits whose mask bit is one, and it changes on the same edge as the event and mask registers.
- R10: After reset, masks and event bits are zero, `irq` is low, and address 0 reads the live conditions with {zeros, ones, los, sync} in bits 3 to 0, which gives 4'b0010.
- R11: `reg_rdata` is registered. It shows the content of `reg_addr` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| reg_addr | input | 2 | Register select: 0 live, 1 events, 2 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Registered read data |
| st_sync | output | 1 | Live lock condition |
| st_los | output | 1 | Live hunting condition |
| st_ones | output | 1 | Live all-ones condition |
| st_zeros | output | 1 | Live all-zeros condition |
| irq | output | 1 | OR of unmasked event bits |

## Verification
A corrupted predictor or match counter shows up at the ports as a wrong lock time: lock arrives early, arrives late, or never arrives. The exact-32 all-zero lock check catches an off-by-one count on the very edge of the 32nd bit. A bad mismatch window only shows at a threshold, so the bench feeds error spacings of 13 and 12 bits, which sit on either side of the limit; the wrong result appears within at most 72 bits. Faults in the event or mask registers appear at `irq` and `reg_rdata` within one or two cycles of the register write or the condition edge.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int STAT_W = 4;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LIVE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_EVENT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;

  // bit 3 zeros, bit 2 ones, bit 1 hunting, bit 0 lock
  typedef struct packed {
    logic zeros;
    logic ones;
    logic los;
    logic sync;
  } bert_stat_t;

  localparam logic [STAT_W-1:0] STAT_RST = 4'b0010;

  typedef enum logic {HUNT = 1'b0, LOCKED = 1'b1} sync_state_t;
endpackage

// File: rtl/bert_prbs_sync.sv
module bert_prbs_sync
  import bert_pkg::*;
#(
  parameter int PRBS_LEN  = 15,
  parameter int TAP_A     = 15,
  parameter int TAP_B     = 14,
  parameter int QUAL_LEN  = 32,
  parameter int ERR_WIN   = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic in_sync,
  output logic lost
);
  localparam int MW = $clog2(QUAL_LEN + 1);
  localparam int EW = $clog2(ERR_WIN + 1);
  localparam logic [MW-1:0] QUAL_LAST = MW'(QUAL_LEN - 1);
  localparam logic [EW-1:0] ERR_LIM   = EW'(ERR_LIMIT);

  sync_state_t         state_q, state_n;
  logic [PRBS_LEN-1:0] sr_q, sr_n;
  logic [MW-1:0]       match_q, match_n;
  logic [ERR_WIN-1:0]  hist_q, hist_n;
  logic [EW-1:0]       ecnt_q, ecnt_n;
  logic                pred, mism;

  assign pred = sr_q[TAP_A-1] ^ sr_q[TAP_B-1];
  assign mism = bit_in ^ pred;

  always_comb begin
    state_n = state_q;
    sr_n    = sr_q;
    match_n = match_q;
    hist_n  = hist_q;
    ecnt_n  = ecnt_q;
    if (bit_vld) begin
      case (state_q)
        HUNT: begin
          sr_n = {sr_q[PRBS_LEN-2:0], bit_in};
          if (mism) begin
            match_n = '0;
          end else if (match_q == QUAL_LAST) begin
            state_n = LOCKED;
            match_n = '0;
          end else begin
            match_n = match_q + 1'b1;
          end
        end
        default: begin
          sr_n   = {sr_q[PRBS_LEN-2:0], pred};
          hist_n = {hist_q[ERR_WIN-2:0], mism};
          ecnt_n = ecnt_q + EW'(mism) - EW'(hist_q[ERR_WIN-1]);
          if (ecnt_n >= ERR_LIM) begin
            state_n = HUNT;
            match_n = '0;
            hist_n  = '0;
            ecnt_n  = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HUNT;
      sr_q    <= '0;
      match_q <= '0;
      hist_q  <= '0;
      ecnt_q  <= '0;
      in_sync <= 1'b0;
      lost    <= 1'b1;
    end else begin
      state_q <= state_n;
      sr_q    <= sr_n;
      match_q <= match_n;
      hist_q  <= hist_n;
      ecnt_q  <= ecnt_n;
      in_sync <= (state_n == LOCKED);
      lost    <= (state_n == HUNT);
    end
  end

  // R3
  los_complement_chk: assert property (@(posedge clk) disable iff (rst)
    lost != in_sync);

  // R4
  lock_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_sync) |-> ($past(bit_vld) && $past(match_q) == QUAL_LAST));

  // R5
  locked_err_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == LOCKED) |-> (ecnt_q < ERR_LIM));

  // R6
  hold_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(sr_q) && $stable(match_q) && $stable(state_q)));
endmodule

// File: rtl/bert_run_det.sv
module bert_run_det #(
  parameter int RUN_LEN = 32,
  parameter bit POL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic run_hit
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_hit <= 1'b0;
    end else if (bit_vld) begin
      if (bit_in == POL) begin
        if (cnt_q != RUN_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == RUN_LAST) run_hit <= 1'b1;
      end else begin
        cnt_q   <= '0;
        run_hit <= 1'b0;
      end
    end
  end

  // R1
  run_release_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_in != POL) |=> !run_hit);

  // R2
  run_qual_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_hit) |-> ($past(cnt_q) == RUN_LAST));

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(cnt_q) && $stable(run_hit)));
endmodule

// File: rtl/bert_stat_regs.sv
module bert_stat_regs
  import bert_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] live,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              irq
);
  logic [STAT_W-1:0] prev_q, evt_q, evt_n, mask_q, mask_n, rise, clr;

  always_comb begin
    rise   = live & ~prev_q;
    clr    = (reg_wr && reg_addr == ADDR_EVENT) ? reg_wdata : '0;
    evt_n  = (evt_q & ~clr) | rise;
    mask_n = (reg_wr && reg_addr == ADDR_MASK) ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= STAT_RST;
      evt_q     <= '0;
      mask_q    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      prev_q <= live;
      evt_q  <= evt_n;
      mask_q <= mask_n;
      irq    <= |(evt_n & mask_n);
      case (reg_addr)
        ADDR_LIVE:  reg_rdata <= live;
        ADDR_EVENT: reg_rdata <= evt_q;
        ADDR_MASK:  reg_rdata <= mask_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((evt_q & $past(rise)) == $past(rise)));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_EVENT && rise == '0) |=> ((evt_q & $past(reg_wdata)) == '0));

  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor
  import bert_pkg::*;
#(
  parameter int PRBS_LEN  = 15,
  parameter int TAP_A     = 15,
  parameter int TAP_B     = 14,
  parameter int QUAL_LEN  = 32,
  parameter int ERR_WIN   = 64,
  parameter int ERR_LIMIT = 6,
  parameter int RUN_LEN   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              rx_valid,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              st_sync,
  output logic              st_los,
  output logic              st_ones,
  output logic              st_zeros,
  output logic              irq
);
  logic [1:0] run_hit;
  bert_stat_t live;

  bert_prbs_sync #(
    .PRBS_LEN(PRBS_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B),
    .QUAL_LEN(QUAL_LEN), .ERR_WIN(ERR_WIN), .ERR_LIMIT(ERR_LIMIT)
  ) u_sync (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid),
    .in_sync(st_sync), .lost(st_los)
  );

  // index 0 watches zeros, index 1 watches ones
  for (genvar g = 0; g < 2; g++) begin : g_run
    bert_run_det #(.RUN_LEN(RUN_LEN), .POL(g[0])) u_run (
      .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid),
      .run_hit(run_hit[g])
    );
  end

  assign st_zeros = run_hit[0];
  assign st_ones  = run_hit[1];

  always_comb begin
    live.zeros = st_zeros;
    live.ones  = st_ones;
    live.los   = st_los;
    live.sync  = st_sync;
  end

  bert_stat_regs u_regs (
    .clk(clk), .rst(rst), .live(live), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // R1
  ones_zeros_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_ones && st_zeros));
endmodule

// File: tb/bert_rx_monitor_bench.sv
module bert_rx_monitor_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b0, rx_valid = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [3:0] reg_wdata = 4'd0, reg_rdata;
  logic       st_sync, st_los, st_ones, st_zeros, irq;

  int n_chk = 0, n_fail = 0;
  logic [14:0] lf = 15'h1ACE;
  logic [3:0]  rv;
  logic [1:0]  kind;
  logic [7:0]  per, len;
  logic [3:0]  exp_st;
  logic        b;

  always #2 clk = ~clk;

  bert_rx_monitor u_bert_rx_monitor (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .st_sync(st_sync), .st_los(st_los),
    .st_ones(st_ones), .st_zeros(st_zeros), .irq(irq)
  );

  // {kind(0 prbs,1 ones,2 zeros), error period, length, expected {zeros,ones,los,sync}}
  localparam int NSEG = 8;
  localparam logic [21:0] SEG [NSEG] = '{
    {2'd0, 8'd0,  8'd100, 4'b0001},
    {2'd0, 8'd8,  8'd64,  4'b0010},
    {2'd1, 8'd0,  8'd40,  4'b0110},
    {2'd2, 8'd0,  8'd34,  4'b1010},
    {2'd1, 8'd0,  8'd1,   4'b0010},
    {2'd0, 8'd0,  8'd100, 4'b0001},
    {2'd0, 8'd13, 8'd130, 4'b0001},
    {2'd0, 8'd12, 8'd80,  4'b0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic v);
    rx_valid = 1'b1; rx_bit = v;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic idle(input logic v);
    rx_valid = 1'b0; rx_bit = v;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] val);
    reg_addr = a;
    @(posedge clk); #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = 4'd0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 live ports", {st_zeros, st_ones, st_los, st_sync}, 4'b0010);
    chk("R10 irq", irq, 0);
    rd(2'd0, rv); chk("R10 live reg", rv, 4'b0010);
    rd(2'd1, rv); chk("R10 events", rv, 0);
    rd(2'd2, rv); chk("R10 mask", rv, 0);

    // table walk: R1 R2 R3 R4 R5
    for (int s = 0; s < NSEG; s++) begin
      {kind, per, len, exp_st} = SEG[s];
      for (int i = 0; i < int'(len); i++) begin
        if (kind == 2'd0) begin
          b  = lf[14] ^ lf[13];
          lf = {lf[13:0], b};
          if (per != 0 && (i % int'(per)) == int'(per) - 1) b = ~b;
        end else begin
          b = (kind == 2'd1);
        end
        send(b);
      end
      chk($sformatf("R5 R4 R3 R1 R2 segment %0d ports", s),
          {st_zeros, st_ones, st_los, st_sync}, exp_st);
      rd(2'd0, rv);
      chk($sformatf("R11 segment %0d live reg", s), rv, exp_st);
    end

    // R7 every condition rose during the table
    rd(2'd1, rv); chk("R7 events all set", rv, 4'b1111);
    chk("R9 irq with zero mask", irq, 0);
    wr(2'd2, 4'b0100);
    chk("R9 irq ones unmasked", irq, 1);
    rd(2'd2, rv); chk("R9 mask readback", rv, 4'b0100);
    wr(2'd1, 4'b0100);
    chk("R7 R9 irq after clear", irq, 0);
    wr(2'd1, 4'b0000);
    rd(2'd1, rv); chk("R7 write zero no effect", rv, 4'b1011);
    wr(2'd2, 4'b1000);
    chk("R9 irq zeros unmasked", irq, 1);
    wr(2'd1, 4'b1011);
    rd(2'd1, rv); chk("R7 cleared", rv, 0);
    chk("R9 irq low", irq, 0);

    // R4 exact lock on 32nd zero from reset
    do_reset();
    for (int i = 0; i < 31; i++) send(1'b0);
    chk("R4 no lock at 31", st_sync, 0);
    chk("R2 no zeros at 31", st_zeros, 0);
    send(1'b0);
    chk("R4 lock at 32", st_sync, 1);
    chk("R3 los low when locked", st_los, 0);
    chk("R2 zeros at 32", st_zeros, 1);
    send(1'b1);
    chk("R2 zeros released by one", st_zeros, 0);

    // R6 hold across invalid cycles, R1 exact count, R8 set wins
    do_reset();
    for (int i = 0; i < 20; i++) send(1'b1);
    for (int i = 0; i < 5; i++) idle(1'b0);
    chk("R6 held no release", st_ones, 0);
    for (int i = 0; i < 11; i++) send(1'b1);
    chk("R1 no ones at 31", st_ones, 0);
    send(1'b1);
    chk("R1 R6 ones at 32", st_ones, 1);
    wr(2'd1, 4'b0100);
    rd(2'd1, rv); chk("R8 set wins over clear", rv[2], 1);
    wr(2'd1, 4'b0100);
    rd(2'd1, rv); chk("R7 clear after event", rv[2], 0);
    send(1'b0);
    chk("R1 ones released by zero", st_ones, 0);
    chk("R3 still hunting", st_los, 1);

    summary();
  end
endmodule